// File: doc/BRIEF.md
# LPC I/O Burst Master

This block lets a host processor reach byte-wide legacy peripherals on a Low Pin Count bus without driving the bus itself. Software configures a direction, a port-address mode, a 16-bit starting port and a byte count. For an output burst it also stages the bytes in a transmit queue. A single kick then runs up to sixteen back-to-back I/O byte cycles on the four-bit multiplexed bus, and the engine handles framing, turnaround, peripheral wait states and error signalling.

Bytes returned by input cycles are collected in a receive queue and popped by successive register reads. A status register separates "engine idle" from "last burst succeeded". An event register holds a sticky completion flag, cleared by writing one to it, which can be routed to an interrupt output. The bus clock is the block clock.

Top module: `lpc_io_burst_master`

## Requirements
- R1: After reset, STAT (offset 0x04) reads 0b01 (bit 0 idle, bit 1 success), EVT (offset 0x08) reads 0, irq is low, lpc_frame_n is high and lpc_lad_oe is low.
- R2: Writing 1 to bit 0 of KICK (offset 0x00) while idle starts a burst of COUNT (offset 0x10) byte cycles. Writes of COUNT outside 1..16 are ignored, and a kick while busy is ignored.
- R3: Each byte cycle holds lpc_frame_n low for exactly one clock with nibble 0000. It then sends a direction nibble (0000 input, 0010 output; CTRL offset 0x14 bit 0 = 1 selects output), four port nibbles most significant first, for output the data byte low nibble first, then drives 1111 for one clock and releases the bus. With no wait states, consecutive cycles start 13 clocks apart.
- R4: With CTRL bit 3 clear, the port (PORT, offset 0x20) rises by one for each byte. With CTRL bit 3 set, every byte uses PORT unchanged.
- R5: Each write to TXQ (offset 0x24) queues its low byte, and bytes go out in queue order. Bytes still queued when a burst completes are discarded.
- R6: Each read of RXQ (offset 0x28) pops the next captured input byte in cycle order; the first data nibble on the bus is the low nibble. A read of an empty queue returns 0, and a kick empties the queue.
- R7: A sync nibble of 0000 means ready, and 0101 or 0110 means wait. A cycle tolerates 255 consecutive waits; the 256th aborts the burst as failed.
- R8: Any other sync nibble aborts the burst. No further cycles start, and STAT reads 0b01.
- R9: STAT bit 0 is 0 while a burst runs. A burst that completes all its cycles leaves STAT at 0b11.
- R10: EVT bit 1 is set by every completion and cleared by writing 1 to it. EVT bit 0 is an interrupt enable, and irq is high when both bits are set.
- R11: CTRL bits [2:1] hold the cycle type. A kick with a non-zero type completes at once without a bus frame, leaving STAT at 0b01 and setting EVT bit 1.
- R12: Writes to COUNT, CTRL, PORT and TXQ while a burst runs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and bus clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RXQ) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Completion interrupt |
| lpc_lad_o | output | 4 | Bus nibble driven by the block |
| lpc_lad_oe | output | 1 | Bus drive enable |
| lpc_lad_i | input | 4 | Bus nibble from the peripheral |
| lpc_frame_n | output | 1 | Active-low cycle frame |

## Verification
The assertions assume that software loads at least COUNT bytes into TXQ before it kicks an output burst, so the engine never pops an empty transmit queue. They also assume that no more than sixteen bytes are queued. The bench keeps to this in every output scenario and never pushes past the queue depth. Its peripheral model follows each frame nibble by nibble and answers only in the sync and data slots, so the bus input stays at 1111 whenever the engine might read it outside those slots.

// File: rtl/lpc_burst_pkg.sv
package lpc_burst_pkg;
   localparam logic [7:0] OFS_KICK  = 8'h00;
   localparam logic [7:0] OFS_STAT  = 8'h04;
   localparam logic [7:0] OFS_EVT   = 8'h08;
   localparam logic [7:0] OFS_COUNT = 8'h10;
   localparam logic [7:0] OFS_CTRL  = 8'h14;
   localparam logic [7:0] OFS_PORT  = 8'h20;
   localparam logic [7:0] OFS_TXQ   = 8'h24;
   localparam logic [7:0] OFS_RXQ   = 8'h28;

   localparam logic [3:0] NIB_FRAME  = 4'h0;
   localparam logic [3:0] NIB_FLOAT  = 4'hF;
   localparam logic [3:0] SYNC_READY = 4'h0;
   localparam logic [3:0] SYNC_WSHRT = 4'h5;
   localparam logic [3:0] SYNC_WLONG = 4'h6;

   typedef enum logic [3:0] {
      E_IDLE, E_START, E_CTDIR, E_ADDR, E_WDAT, E_TAR1, E_TAR2,
      E_SYNC, E_RDAT, E_END1, E_END2
   } eng_state_t;
endpackage

// File: rtl/lpc_byte_queue.sv
module lpc_byte_queue #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] PTR_ONE = 1;
   localparam logic [AW:0]   CNT_ONE = 1;
   localparam logic [AW:0]   CNT_MAX = DEPTH;

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("queue depth must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_MAX);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + PTR_ONE;
         if (do_pop)  rp <= rp + PTR_ONE;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CNT_ONE;
            2'b01:   cnt <= cnt - CNT_ONE;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop && !flush |-> !empty); // R5
endmodule

// File: rtl/lpc_cycle_engine.sv
module lpc_cycle_engine
   import lpc_burst_pkg::*;
#(
   parameter int PORT_W     = 16,
   parameter int LEN_W      = 5,
   parameter int WAIT_LIMIT = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_write,
   input  logic              same_port,
   input  logic [PORT_W-1:0] base_port,
   input  logic [LEN_W-1:0]  len,
   input  logic [7:0]        tx_byte,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [7:0]        rx_byte,
   output logic              done,
   output logic              ok,
   output logic              busy,
   input  logic [3:0]        lad_i,
   output logic [3:0]        lad_o,
   output logic              lad_oe,
   output logic              frame_n
);
   localparam int NIBS  = PORT_W / 4;
   localparam int NIB_W = (NIBS > 2) ? $clog2(NIBS) : 1;
   localparam int WCW   = $clog2(WAIT_LIMIT);
   localparam logic [NIB_W-1:0]  NIB_ONE   = 1;
   localparam logic [NIB_W-1:0]  NIB_LAST  = NIB_W'(NIBS - 1);
   localparam logic [WCW-1:0]    WAIT_ONE  = 1;
   localparam logic [WCW-1:0]    WAIT_LAST = WCW'(WAIT_LIMIT - 1);
   localparam logic [LEN_W-1:0]  REM_ONE   = 1;
   localparam logic [PORT_W-1:0] PORT_ONE  = 1;

   generate
      if (PORT_W % 4 != 0 || PORT_W < 8) begin : g_bad_port
         $error("port width must be a multiple of 4 and at least 8");
      end
      if (WAIT_LIMIT < 2) begin : g_bad_wait
         $error("wait limit must be at least 2");
      end
   endgenerate

   eng_state_t        state;
   logic [NIB_W-1:0]  nib;
   logic [PORT_W-1:0] cur_port, port_sh;
   logic [LEN_W-1:0]  rem;
   logic [WCW-1:0]    wait_cnt;
   logic [3:0]        lo_q;
   logic              wr_q, same_q;
   logic              sync_ready, sync_wait;

   assign sync_ready = (lad_i == SYNC_READY);
   assign sync_wait  = (lad_i == SYNC_WSHRT) || (lad_i == SYNC_WLONG);
   assign port_sh    = cur_port >> (4 * (NIBS - 1 - int'(nib)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= E_IDLE;
         nib      <= '0;
         cur_port <= '0;
         rem      <= '0;
         wait_cnt <= '0;
         lo_q     <= '0;
         wr_q     <= 1'b0;
         same_q   <= 1'b0;
      end else begin
         case (state)
            E_IDLE: if (start) begin
               state    <= E_START;
               cur_port <= base_port;
               rem      <= len;
               wr_q     <= is_write;
               same_q   <= same_port;
            end
            E_START: state <= E_CTDIR;
            E_CTDIR: begin
               state <= E_ADDR;
               nib   <= '0;
            end
            E_ADDR: if (nib == NIB_LAST) begin
               nib   <= '0;
               state <= wr_q ? E_WDAT : E_TAR1;
            end else nib <= nib + NIB_ONE;
            E_WDAT: if (nib == NIB_ONE) begin
               nib   <= '0;
               state <= E_TAR1;
            end else nib <= nib + NIB_ONE;
            E_TAR1: state <= E_TAR2;
            E_TAR2: begin
               state    <= E_SYNC;
               wait_cnt <= '0;
            end
            E_SYNC: if (sync_ready) begin
               state <= wr_q ? E_END1 : E_RDAT;
               nib   <= '0;
            end else if (sync_wait && wait_cnt != WAIT_LAST) begin
               wait_cnt <= wait_cnt + WAIT_ONE;
            end else begin
               state <= E_IDLE;
            end
            E_RDAT: if (nib == NIB_ONE) begin
               nib   <= '0;
               state <= E_END1;
            end else begin
               lo_q <= lad_i;
               nib  <= nib + NIB_ONE;
            end
            E_END1: state <= E_END2;
            E_END2: if (rem == REM_ONE) begin
               state <= E_IDLE;
            end else begin
               state <= E_START;
               rem   <= rem - REM_ONE;
               if (!same_q) cur_port <= cur_port + PORT_ONE;
            end
            default: state <= E_IDLE;
         endcase
      end
   end

   always_comb begin
      lad_o = NIB_FLOAT;
      case (state)
         E_START: lad_o = NIB_FRAME;
         E_CTDIR: lad_o = {2'b00, wr_q, 1'b0};
         E_ADDR:  lad_o = port_sh[3:0];
         E_WDAT:  lad_o = (nib == '0) ? tx_byte[3:0] : tx_byte[7:4];
         default: lad_o = NIB_FLOAT;
      endcase
   end

   assign lad_oe  = (state == E_START) || (state == E_CTDIR) || (state == E_ADDR) ||
                    (state == E_WDAT)  || (state == E_TAR1);
   assign frame_n = (state != E_START);
   assign busy    = (state != E_IDLE);
   assign tx_pop  = (state == E_WDAT) && (nib == NIB_ONE);
   assign rx_push = (state == E_RDAT) && (nib == NIB_ONE);
   assign rx_byte = {lad_i, lo_q};
   assign ok      = (state == E_END2);
   assign done    = ((state == E_END2) && (rem == REM_ONE)) ||
                    ((state == E_SYNC) && !sync_ready && (!sync_wait || wait_cnt == WAIT_LAST));

   AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !frame_n |=> frame_n); // R3
   AST_BAD_SYNC_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == E_SYNC) && !sync_ready && !sync_wait |=> !busy && frame_n); // R8
   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R9
endmodule

// File: rtl/lpc_io_burst_master.sv
module lpc_io_burst_master
   import lpc_burst_pkg::*;
#(
   parameter int MAX_BURST  = 16,
   parameter int PORT_W     = 16,
   parameter int WAIT_LIMIT = 256,
   parameter int REG_W      = 32,
   parameter bit IRQ_FLOP   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [7:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq,
   output logic [3:0]       lpc_lad_o,
   output logic             lpc_lad_oe,
   input  logic [3:0]       lpc_lad_i,
   output logic             lpc_frame_n
);
   localparam int LEN_W = $clog2(MAX_BURST + 1);
   localparam logic [REG_W-1:0] LEN_MAX = REG_W'(MAX_BURST);
   localparam logic [LEN_W-1:0] LEN_RST = 1;

   generate
      if (REG_W < PORT_W || REG_W < 8) begin : g_bad_regw
         $error("register width too small for the port field");
      end
   endgenerate

   logic [LEN_W-1:0]  cnt_q;
   logic [PORT_W-1:0] port_q;
   logic [1:0]        ctrl_type;
   logic              ctrl_wr, ctrl_same, ok_q, evt_en, evt_flag;
   logic              idle, eng_busy, eng_done, eng_ok;
   logic              kick, eng_start, type_fail, fin;
   logic              tx_pop, tx_empty, tx_full, rx_push, rx_pop, rx_empty, rx_full;
   logic [7:0]        tx_head, rx_head, rx_byte;

   assign idle      = !eng_busy;
   assign kick      = reg_wr && (reg_addr == OFS_KICK) && reg_wdata[0] && idle;
   assign eng_start = kick && (ctrl_type == 2'b00);
   assign type_fail = kick && (ctrl_type != 2'b00);
   assign fin       = eng_done || type_fail;
   assign rx_pop    = reg_rd && (reg_addr == OFS_RXQ) && !rx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= LEN_RST;
         port_q    <= '0;
         ctrl_type <= 2'b00;
         ctrl_wr   <= 1'b0;
         ctrl_same <= 1'b0;
      end else if (reg_wr && idle) begin
         if (reg_addr == OFS_COUNT && reg_wdata != '0 && reg_wdata <= LEN_MAX)
            cnt_q <= reg_wdata[LEN_W-1:0];
         if (reg_addr == OFS_PORT)
            port_q <= reg_wdata[PORT_W-1:0];
         if (reg_addr == OFS_CTRL) begin
            ctrl_wr   <= reg_wdata[0];
            ctrl_type <= reg_wdata[2:1];
            ctrl_same <= reg_wdata[3];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_q     <= 1'b0;
         evt_en   <= 1'b0;
         evt_flag <= 1'b0;
      end else begin
         if (eng_start)  ok_q <= 1'b0;
         else if (fin)   ok_q <= eng_done && eng_ok;
         if (reg_wr && reg_addr == OFS_EVT) evt_en <= reg_wdata[0];
         if (fin)        evt_flag <= 1'b1;
         else if (reg_wr && reg_addr == OFS_EVT && reg_wdata[1]) evt_flag <= 1'b0;
      end
   end

   generate
      if (IRQ_FLOP) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= evt_en && evt_flag;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = evt_en && evt_flag;
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_STAT:  reg_rdata[1:0]        = {ok_q, idle};
         OFS_EVT:   reg_rdata[1:0]        = {evt_flag, evt_en};
         OFS_COUNT: reg_rdata[LEN_W-1:0]  = cnt_q;
         OFS_CTRL:  reg_rdata[3:0]        = {ctrl_same, ctrl_type, ctrl_wr};
         OFS_PORT:  reg_rdata[PORT_W-1:0] = port_q;
         OFS_RXQ:   reg_rdata[7:0]        = rx_empty ? 8'h00 : rx_head;
         default:   reg_rdata             = '0;
      endcase
   end

   lpc_byte_queue #(.W(8), .DEPTH(MAX_BURST)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(fin),
      .push(reg_wr && reg_addr == OFS_TXQ && idle), .din(reg_wdata[7:0]),
      .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full)
   );

   lpc_byte_queue #(.W(8), .DEPTH(MAX_BURST)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(eng_start),
      .push(rx_push), .din(rx_byte),
      .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full)
   );

   lpc_cycle_engine #(.PORT_W(PORT_W), .LEN_W(LEN_W), .WAIT_LIMIT(WAIT_LIMIT)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .is_write(ctrl_wr),
      .same_port(ctrl_same), .base_port(port_q), .len(cnt_q),
      .tx_byte(tx_head), .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
      .done(eng_done), .ok(eng_ok), .busy(eng_busy),
      .lad_i(lpc_lad_i), .lad_o(lpc_lad_o), .lad_oe(lpc_lad_oe), .frame_n(lpc_frame_n)
   );

   AST_KICK_BUSY: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !idle && !ok_q); // R9
   AST_FIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n) fin |=> evt_flag); // R10
   AST_TYPE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n) type_fail |=> lpc_frame_n && idle); // R11
   AST_TX_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> !tx_empty); // R5
   AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> !rx_full); // R6
endmodule

// File: tb/tb_lpc_io_burst_master.sv
`timescale 1ns/1ps
module tb_lpc_io_burst_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, lpc_lad_oe, lpc_frame_n;
   logic [3:0]  lpc_lad_o;
   logic [3:0]  lpc_lad_i = 4'hF;

   int n_chk = 0, n_bad = 0;
   int tick = 0;
   int cap_n = 0, err_at = -1, sync_waits = 0;
   bit periph_busy = 1'b0;
   logic [15:0] cap_addr [64];
   logic [3:0]  cap_ct   [64];
   logic [7:0]  cap_data [64];
   int          cap_t    [64];

   always #2.5 clk = ~clk;
   always @(posedge clk) tick <= tick + 1;

   lpc_io_burst_master dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .lpc_lad_o(lpc_lad_o),
      .lpc_lad_oe(lpc_lad_oe), .lpc_lad_i(lpc_lad_i), .lpc_frame_n(lpc_frame_n)
   );

   function automatic logic [7:0] rd_byte(input int i);
      return 8'hC0 ^ 8'(i * 19);
   endfunction

   // peripheral model
   int          p_idx;
   logic [3:0]  p_ct;
   logic [15:0] p_a;
   logic [7:0]  p_d;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && !lpc_frame_n) begin
            periph_busy = 1'b1;
            p_idx = cap_n;
            cap_t[p_idx] = tick;
            @(negedge clk) p_ct = lpc_lad_o;
            p_a = '0;
            repeat (4) begin @(negedge clk); p_a = {p_a[11:0], lpc_lad_o}; end
            p_d = '0;
            if (p_ct == 4'h2) begin
               @(negedge clk); p_d[3:0] = lpc_lad_o;
               @(negedge clk); p_d[7:4] = lpc_lad_o;
            end
            cap_addr[p_idx] = p_a; cap_ct[p_idx] = p_ct; cap_data[p_idx] = p_d;
            cap_n = p_idx + 1;
            @(negedge clk); @(negedge clk);
            if (p_idx == err_at) begin
               @(negedge clk); lpc_lad_i = 4'hA;
               @(negedge clk); lpc_lad_i = 4'hF;
            end else begin
               for (int w = 0; w < sync_waits; w++) begin @(negedge clk); lpc_lad_i = 4'h6; end
               @(negedge clk); lpc_lad_i = 4'h0;
               if (p_ct == 4'h0) begin
                  p_d = rd_byte(p_idx);
                  @(negedge clk); lpc_lad_i = p_d[3:0];
                  @(negedge clk); lpc_lad_i = p_d[7:4];
               end
               @(negedge clk); lpc_lad_i = 4'hF;
               @(negedge clk);
            end
            periph_busy = 1'b0;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1; d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      int g = 0;
      do begin reg_read(8'h04, s); g++; end while (!s[0] && g < 5000);
      while (periph_busy) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      reg_read(8'h04, d); chk("R1 stat", d, 32'h1);
      reg_read(8'h08, d); chk("R1 evt", d, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 frame", {30'b0, lpc_frame_n, lpc_lad_oe}, 32'h2);
   endtask

   task automatic t_write_incr();
      logic [31:0] d;
      int b = cap_n;
      reg_write(8'h08, 32'h1);
      reg_write(8'h10, 32'd3);
      reg_write(8'h14, 32'h1);
      reg_write(8'h20, 32'h02F8);
      reg_write(8'h24, 32'hA1); reg_write(8'h24, 32'hB2); reg_write(8'h24, 32'hC3);
      reg_write(8'h00, 32'h1);
      reg_read(8'h04, d); chk("R9 busy", {31'b0, d[0]}, 32'h0);
      wait_idle();
      chk("R2 count", cap_n - b, 3);
      for (int i = 0; i < 3; i++) begin
         chk("R4 incr addr", {16'b0, cap_addr[b+i]}, 32'h02F8 + i);
         chk("R3 dir write", {28'b0, cap_ct[b+i]}, 32'h2);
      end
      chk("R5 byte0", {24'b0, cap_data[b]}, 32'hA1);
      chk("R5 byte1", {24'b0, cap_data[b+1]}, 32'hB2);
      chk("R5 byte2", {24'b0, cap_data[b+2]}, 32'hC3);
      chk("R3 spacing write", cap_t[b+1] - cap_t[b], 13);
      reg_read(8'h04, d); chk("R9 ok", d, 32'h3);
      @(negedge clk);
      chk("R10 irq set", {31'b0, irq}, 32'h1);
      reg_read(8'h08, d); chk("R10 evt", d, 32'h3);
      reg_write(8'h08, 32'h3);
      @(negedge clk);
      reg_read(8'h08, d); chk("R10 w1c", d, 32'h1);
      chk("R10 irq clear", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_read_fixed();
      logic [31:0] d;
      int b = cap_n;
      reg_write(8'h10, 32'd4);
      reg_write(8'h14, 32'h8);
      reg_write(8'h20, 32'h00E4);
      reg_write(8'h00, 32'h1);
      wait_idle();
      chk("R2 count read", cap_n - b, 4);
      for (int i = 0; i < 4; i++) begin
         chk("R4 fixed addr", {16'b0, cap_addr[b+i]}, 32'h00E4);
         chk("R3 dir read", {28'b0, cap_ct[b+i]}, 32'h0);
      end
      chk("R3 spacing read", cap_t[b+1] - cap_t[b], 13);
      for (int i = 0; i < 4; i++) begin
         reg_read(8'h28, d); chk("R6 pop order", d, {24'b0, rd_byte(b+i)});
      end
      reg_read(8'h28, d); chk("R6 empty", d, 32'h0);
   endtask

   task automatic t_read_max();
      logic [31:0] d;
      int b = cap_n;
      reg_write(8'h10, 32'd16);
      reg_write(8'h14, 32'h0);
      reg_write(8'h20, 32'h0FF8);
      reg_write(8'h00, 32'h1);
      wait_idle();
      chk("R2 count 16", cap_n - b, 16);
      chk("R4 carry addr", {16'b0, cap_addr[b+15]}, 32'h1007);
      for (int i = 0; i < 16; i++) begin
         reg_read(8'h28, d); chk("R6 pop 16", d, {24'b0, rd_byte(b+i)});
      end
   endtask

   task automatic t_waits();
      logic [31:0] d;
      int b;
      reg_write(8'h10, 32'd1);
      reg_write(8'h14, 32'h0);
      sync_waits = 255;
      b = cap_n;
      reg_write(8'h00, 32'h1);
      wait_idle();
      reg_read(8'h04, d); chk("R7 255 waits ok", d, 32'h3);
      reg_read(8'h28, d); chk("R7 data after waits", d, {24'b0, rd_byte(b)});
      sync_waits = 256;
      reg_write(8'h00, 32'h1);
      wait_idle();
      reg_read(8'h04, d); chk("R7 256 waits abort", d, 32'h1);
      reg_read(8'h08, d); chk("R10 flag on fail", {31'b0, d[1]}, 32'h1);
      sync_waits = 0;
   endtask

   task automatic t_error();
      logic [31:0] d;
      int b = cap_n;
      err_at = b + 1;
      reg_write(8'h10, 32'd3);
      reg_write(8'h14, 32'h1);
      reg_write(8'h24, 32'h11); reg_write(8'h24, 32'h22); reg_write(8'h24, 32'h33);
      reg_write(8'h00, 32'h1);
      wait_idle();
      repeat (30) @(negedge clk);
      chk("R8 stop frames", cap_n - b, 2);
      reg_read(8'h04, d); chk("R8 status", d, 32'h1);
      err_at = -1;
      b = cap_n;
      reg_write(8'h10, 32'd1);
      reg_write(8'h24, 32'h77);
      reg_write(8'h00, 32'h1);
      wait_idle();
      chk("R5 leftover dropped", {24'b0, cap_data[b]}, 32'h77);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] d;
      int b = cap_n;
      reg_write(8'h10, 32'd2);
      reg_write(8'h14, 32'h0);
      reg_write(8'h20, 32'h0300);
      reg_write(8'h00, 32'h1);
      reg_write(8'h20, 32'h1234);
      reg_write(8'h10, 32'd5);
      reg_write(8'h14, 32'h9);
      reg_write(8'h00, 32'h1);
      wait_idle();
      repeat (30) @(negedge clk);
      chk("R2 kick while busy", cap_n - b, 2);
      reg_read(8'h20, d); chk("R12 port kept", d, 32'h0300);
      reg_read(8'h10, d); chk("R12 count kept", d, 32'd2);
      reg_read(8'h14, d); chk("R12 ctrl kept", d, 32'h0);
      reg_write(8'h10, 32'd0);
      reg_read(8'h10, d); chk("R2 count 0 ignored", d, 32'd2);
      reg_write(8'h10, 32'd17);
      reg_read(8'h10, d); chk("R2 count 17 ignored", d, 32'd2);
      b = cap_n;
      reg_write(8'h10, 32'd1);
      reg_write(8'h00, 32'h1);
      wait_idle();
      reg_read(8'h28, d); chk("R6 flush on kick", d, {24'b0, rd_byte(b)});
      reg_read(8'h28, d); chk("R6 empty after flush", d, 32'h0);
   endtask

   task automatic t_type();
      logic [31:0] d;
      int b = cap_n;
      reg_write(8'h08, 32'h2);
      reg_write(8'h14, 32'h2);
      reg_write(8'h00, 32'h1);
      repeat (20) @(negedge clk);
      chk("R11 no frame", cap_n - b, 0);
      reg_read(8'h04, d); chk("R11 status", d, 32'h1);
      reg_read(8'h08, d); chk("R11 flag", d, 32'h2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_incr();
      t_read_fixed();
      t_read_max();
      t_waits();
      t_error();
      t_busy_ignore();
      t_type();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule